// File: doc/BRIEF.md
# Slave Address Match Detector

This block watches the byte that a serial two-wire bus receiver delivers right after a START condition. It decides whether that byte addresses this node. The surrounding controller supplies the byte with a valid strobe, along with a marker that says the byte is the first one of the transfer. It also supplies the programmed own-address register, the addressing format, and the bus-event strobes.

The block keeps two sticky flags. One says the node was addressed. The other says a broadcast (general call, byte 0x00) was seen. When either flag is set by a byte, the block also emits a one-cycle pulse. The controller uses that pulse to hold the clock line low until software services the transfer.

Each flag has its own clear rule:
- The address flag clears when software writes the data register while the interface is enabled.
- The broadcast flag clears on any START or STOP.

In 10-bit format only the first address byte is compared. That byte is compared against all eight register bits.

Top module: `slv_addr_detect`

## Requirements
- R1: After synchronous reset, `match_flag`, `gcall_flag` and `hold_pulse` are 0.
- R2: In 7-bit format (`fmt_10bit`=0), an evaluated byte sets `match_flag` when `rx_byte[7:1]` equals `own_addr[7:1]`. Bit 0 (the read/write bit) is not compared.
- R3: An evaluated byte equal to 0x00 sets `gcall_flag` in either format. In 7-bit format it also sets `match_flag`.
- R4: In 10-bit format, an evaluated byte sets `match_flag` only when all 8 bits equal `own_addr`.
- R5: A byte is evaluated only when `rx_valid`=1, `first_byte`=1, `enable`=1 and `cmp_disable`=0. Otherwise it changes no flag.
- R6: A byte with `first_byte`=0 leaves both flags unchanged.
- R7: `data_wr` with `enable`=1 clears `match_flag` on the next edge. `data_wr` with `enable`=0 has no effect.
- R8: `start_det` or `stop_det` clears `gcall_flag` and leaves `match_flag` unchanged.
- R9: `hold_pulse` is high for the one cycle after an evaluated byte that either matches or is a general call. Otherwise it is low.
- R10: When a flag is set and cleared in the same cycle, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Interface enable |
| cmp_disable | input | 1 | 1 = address comparison off |
| fmt_10bit | input | 1 | 0 = 7-bit format, 1 = 10-bit format |
| own_addr | input | 8 | Programmed own-address register |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| first_byte | input | 1 | Byte is the first one after START |
| start_det | input | 1 | START detected strobe |
| stop_det | input | 1 | STOP detected strobe |
| data_wr | input | 1 | Data register write strobe |
| match_flag | output | 1 | Node addressed |
| gcall_flag | output | 1 | General call received |
| hold_pulse | output | 1 | One-cycle request to stall the bus |

## Verification
The hardest case to reach is a set and a clear arriving in the same cycle. Examples are a data-register write that lands on the same edge as a matching first byte, or a START strobe that coincides with a broadcast byte. The vector table drives these combinations on the same edge, so the priority of the set can be observed directly.

Stateful sequences are also covered. In these, a flag survives a clear that is gated off (a write while disabled, or a STOP that leaves the address flag alone). These sequences are reached by ordering the vectors so that each one starts from the flag state left by the one before.

// File: rtl/slv_addr_pkg.sv
package slv_addr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        FMT_7BIT  = 1'b0,
        FMT_10BIT = 1'b1
    } addr_fmt_e;

    typedef struct packed {
        logic addr_hit;
        logic gen_call;
    } cmp_res_t;

    function automatic logic is_gen_call(input logic [BYTE_W-1:0] b);
        return (b == '0);
    endfunction

    function automatic logic hit_7bit(input logic [BYTE_W-1:0] b,
                                      input logic [BYTE_W-1:0] reg_val);
        return (b[BYTE_W-1:1] == reg_val[BYTE_W-1:1]);
    endfunction

endpackage

// File: rtl/slv_addr_compare.sv
module slv_addr_compare
    import slv_addr_pkg::*;
(
    input  addr_fmt_e            fmt,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic [BYTE_W-1:0]    own_addr,
    output cmp_res_t             res
);
    logic gc;

    always_comb begin
        gc = is_gen_call(rx_byte);
        res.gen_call = gc;
        if (fmt == FMT_10BIT) begin
            res.addr_hit = (rx_byte == own_addr);
        end else begin
            res.addr_hit = hit_7bit(rx_byte, own_addr) | gc;
        end
    end
endmodule

// File: rtl/slv_flag_cell.sv
module slv_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q);
endmodule

// File: rtl/slv_addr_detect.sv
module slv_addr_detect
    import slv_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cmp_disable,
    input  logic              fmt_10bit,
    input  logic [7:0]        own_addr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              first_byte,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              data_wr,
    output logic              match_flag,
    output logic              gcall_flag,
    output logic              hold_pulse
);
    localparam int NFLAG = 2;

    addr_fmt_e  fmt;
    cmp_res_t   cmp;
    logic       eval_en;
    logic [NFLAG-1:0] set_v, clr_v, q_v;

    assign fmt     = addr_fmt_e'(fmt_10bit);
    assign eval_en = rx_valid & first_byte & enable & ~cmp_disable;

    slv_addr_compare u_cmp (
        .fmt      (fmt),
        .rx_byte  (rx_byte),
        .own_addr (own_addr),
        .res      (cmp)
    );

    assign set_v[0] = eval_en & cmp.addr_hit;
    assign clr_v[0] = data_wr & enable;
    assign set_v[1] = eval_en & cmp.gen_call;
    assign clr_v[1] = start_det | stop_det;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        slv_flag_cell u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q     (q_v[i])
        );
    end

    assign match_flag = q_v[0];
    assign gcall_flag = q_v[1];

    always_ff @(posedge clk) begin
        if (rst) hold_pulse <= 1'b0;
        else     hold_pulse <= eval_en & (cmp.addr_hit | cmp.gen_call);
    end

    p_wr_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (data_wr && enable && !set_v[0]) |=> !match_flag);

    p_bus_evt_clears_r8: assert property (@(posedge clk) disable iff (rst)
        ((start_det || stop_det) && !set_v[1]) |=> !gcall_flag);

    p_pulse_has_flag_r9: assert property (@(posedge clk) disable iff (rst)
        hold_pulse |-> (match_flag || gcall_flag));

    p_later_byte_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (!first_byte && !data_wr && !start_det && !stop_det)
        |=> ($stable(match_flag) && $stable(gcall_flag)));

    p_cmp_off_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp_disable && !data_wr && !start_det && !stop_det)
        |=> ($stable(match_flag) && $stable(gcall_flag) && !hold_pulse));
endmodule

// File: tb/slv_addr_detect_tb.sv
module slv_addr_detect_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, cmp_disable = 1'b0, fmt_10bit = 1'b0;
    logic [7:0] own_addr = 8'hA4;
    logic rx_valid = 1'b0, first_byte = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic start_det = 1'b0, stop_det = 1'b0, data_wr = 1'b0;
    logic match_flag, gcall_flag, hold_pulse;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    slv_addr_detect u_dut (
        .clk(clk), .rst(rst), .enable(enable), .cmp_disable(cmp_disable),
        .fmt_10bit(fmt_10bit), .own_addr(own_addr), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .first_byte(first_byte), .start_det(start_det),
        .stop_det(stop_det), .data_wr(data_wr), .match_flag(match_flag),
        .gcall_flag(gcall_flag), .hold_pulse(hold_pulse)
    );

    typedef struct packed {
        logic       f10, dis, en, fst, vld;
        logic [7:0] d;
        logic       wr, sta, sto;
        logic       em, eg, ep;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 20;
    // own_addr = 0xA4 throughout
    localparam vec_t TBL [NV] = '{
        '{0,0,1,1,1,8'hA5,0,0,0, 1,0,1, 2},  // R2 rw bit ignored
        '{0,0,1,0,0,8'h00,0,0,0, 1,0,0, 9},  // R9 pulse drops
        '{0,0,1,0,0,8'h00,1,0,0, 0,0,0, 7},  // R7 write clears
        '{0,0,1,1,1,8'hA6,0,0,0, 0,0,0, 2},  // R2 address bit differs
        '{0,0,1,1,1,8'h00,0,0,0, 1,1,1, 3},  // R3 general call
        '{0,0,1,0,0,8'h00,0,0,1, 1,0,0, 8},  // R8 stop clears gc only
        '{0,0,1,0,0,8'h00,1,0,0, 0,0,0, 7},  // R7
        '{0,0,1,0,1,8'hA4,0,0,0, 0,0,0, 6},  // R6 not first byte
        '{0,1,1,1,1,8'hA4,0,0,0, 0,0,0, 5},  // R5 compare disabled
        '{0,0,0,1,1,8'hA4,0,0,0, 0,0,0, 5},  // R5 interface disabled
        '{1,0,1,1,1,8'hA5,0,0,0, 0,0,0, 4},  // R4 rw bit compared
        '{1,0,1,1,1,8'hA4,0,0,0, 1,0,1, 4},  // R4 full match
        '{0,0,0,0,0,8'h00,1,0,0, 1,0,0, 7},  // R7 write while disabled
        '{0,0,1,1,1,8'hA4,1,0,0, 1,0,1,10},  // R10 set beats write
        '{0,0,1,1,1,8'h00,0,0,0, 1,1,1, 3},  // R3
        '{0,0,1,0,0,8'h00,0,1,0, 1,0,0, 8},  // R8 start clears gc only
        '{0,0,1,0,0,8'h00,1,0,0, 0,0,0, 7},  // R7
        '{1,0,1,1,1,8'h00,0,0,0, 0,1,1, 3},  // R3 gc in 10-bit, no match
        '{0,0,1,0,0,8'h00,0,1,0, 0,0,0, 8},  // R8
        '{0,0,1,1,1,8'h00,0,1,0, 1,1,1,10}   // R10 gc beats start
    };

    task automatic chk(input logic act, input logic exp, input int rq, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
        end
    endtask

    task automatic chk_all(input logic em, input logic eg, input logic ep, input int rq);
        chk(match_flag, em, rq, "match_flag");
        chk(gcall_flag, eg, rq, "gcall_flag");
        chk(hold_pulse, ep, rq, "hold_pulse");
    endtask

    initial begin : watchdog
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all(1'b0, 1'b0, 1'b0, 1);    // R1 reset state
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            fmt_10bit = TBL[i].f10; cmp_disable = TBL[i].dis; enable = TBL[i].en;
            first_byte = TBL[i].fst; rx_valid = TBL[i].vld; rx_byte = TBL[i].d;
            data_wr = TBL[i].wr; start_det = TBL[i].sta; stop_det = TBL[i].sto;
            @(posedge clk);
            @(negedge clk);
            chk_all(TBL[i].em, TBL[i].eg, TBL[i].ep, int'(TBL[i].rq));
        end
        // idle: last vector's pulse must drop (R9)
        {rx_valid, first_byte, start_det, stop_det, data_wr} = '0;
        @(posedge clk); @(negedge clk);
        chk_all(1'b1, 1'b1, 1'b0, 9);
        // mid-run reset clears everything (R1)
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_all(1'b0, 1'b0, 1'b0, 1);
        rst = 1'b0;
        // 7-bit match with different own address, rw bit set (R2)
        own_addr = 8'h3C; fmt_10bit = 1'b0; enable = 1'b1;
        rx_valid = 1'b1; first_byte = 1'b1; rx_byte = 8'h3D;
        @(posedge clk); @(negedge clk);
        chk_all(1'b1, 1'b0, 1'b1, 2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule